// File: doc/BRIEF.md
# Two-Stage Keyed Watchdog Timer

This block is a register-mapped watchdog that counts down in two stages. A 20-bit counter first runs down from a stage-1 preload. When it passes zero it takes a stage-2 preload, records a pending interrupt and keeps counting. When stage 2 also passes zero, the block sets a sticky timeout flag. It raises a reset request if reboot is enabled. A free-running prescaler turns the input clock into the decrement tick, at one of two selectable rates.

The two preloads and the reload register are protected. Before software can write one of them, it must write the key byte 0x80 and then 0x86 to the reload address. That opens the gate for exactly one protected write. The enable bit can be frozen with a lock bit that only a block reset releases. The timeout flag sits on its own power-on reset, so it survives the block reset that the request causes. Software can therefore still see, after the restart, that the watchdog fired.

The register port is a plain single-cycle write strobe plus an asynchronous read address. Writes always complete, so there is no back-pressure. Word addresses: 0 stage-1 preload, 1 stage-2 preload, 2 status, 3 reload/key, 4 config, 5 lock/enable, 6 count (read only).

Top module: `keyed_wdog`

## Requirements
- R1: A write of 0x80 and then 0x86 to the reload address (3) opens the key gate. Exactly one following write to a protected register (addresses 0, 1, 3) takes effect, and the gate then closes.
- R2: While the gate is half open (after 0x80), any write other than 0x86 to address 3 returns it to closed. That includes a wrong byte or a write to another address.
- R3: While the gate is closed, writes to addresses 0, 1 and 3 change no register and no count, except that 0x80 to address 3 starts the key.
- R4: An admitted reload write with bit 8 set loads the counter from the stage-1 preload and selects stage 1.
- R5: When stage 1 passes zero, the counter loads the stage-2 preload and status bit 0 is set. Output irq is high while that bit is set, the timer is enabled, and config bits [1:0] are not 0b11. Writing 1 to status bit 0 clears it.
- R6: When stage 2 passes zero in watchdog mode, the timeout flag is set and the counter restarts stage 1 from its preload. If config bit 5 is set, rst_req also rises and stays high until rst_n.
- R7: Lock/enable register bits are: bit 0 lock, bit 1 enable, bit 2 mode (0 watchdog, 1 free timer). Once lock is 1, writes to this register are ignored until rst_n.
- R8: With enable 0 the count and stage hold and irq is low.
- R9: Config bit 2 selects the tick rate: 0 gives one tick per 2^SLOW_LOG2 clocks, 1 gives one tick per 2^FAST_LOG2 clocks. Each tick lowers the count by one, so a stage with preload N lasts N+1 ticks.
- R10: Reload-register bit 9 reads the timeout flag. An admitted write with bit 9 set clears it. rst_n leaves it unchanged, and only por_n resets it.
- R11: Address 6 reads the count in bits [19:0] and the stage in bit 20 (1 = stage 2).
- R12: In free-timer mode, a stage-2 expiry sets neither the timeout flag nor rst_req.
- R13: After reset, the preloads and count hold 0xFFFFF in stage 1. Config, lock/enable and status read 0, and irq and rst_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| por_n | input | 1 | Active-low power-on reset for the timeout flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data for rd_addr |
| irq | output | 1 | Stage-1 interrupt |
| rst_req | output | 1 | System reset request |

## Verification
A key state machine stuck in the wrong state shows on the very next protected write. The preload or count read-back either changes when it should not, or stays unchanged when it should move. A counter or stage error shows as a wrong count or stage bit at the expiry edge itself. A tick-rate error shows as a wrong decrement over a fixed window, or a stage-2 length other than exactly 4×(N+1) clocks. A flag tied to the wrong reset is visible on the first read after rst_n.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [2:0] A_PRE1 = 3'd0;
  localparam logic [2:0] A_PRE2 = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_RLD  = 3'd3;
  localparam logic [2:0] A_CFG  = 3'd4;
  localparam logic [2:0] A_LOCK = 3'd5;
  localparam logic [2:0] A_CNT  = 3'd6;

  localparam logic [7:0] KEY_A = 8'h80;
  localparam logic [7:0] KEY_B = 8'h86;

  localparam int RLD_GO_BIT   = 8;
  localparam int RLD_FLAG_BIT = 9;
  localparam int CFG_FAST_BIT = 2;
  localparam int CFG_BOOT_BIT = 5;

  typedef enum logic [1:0] {
    K_SHUT = 2'd0,
    K_HALF = 2'd1,
    K_OPEN = 2'd2
  } key_state_t;
endpackage

// File: rtl/wdog_key.sv
module wdog_key
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       is_rld,
  input  logic       is_prot,
  input  logic [7:0] wr_byte,
  output logic       grant
);
  key_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      K_SHUT: if (wr_en && is_rld && wr_byte == KEY_A) st_d = K_HALF;
      K_HALF: if (wr_en) st_d = (is_rld && wr_byte == KEY_B) ? K_OPEN : K_SHUT;
      K_OPEN: if (wr_en && is_prot) st_d = K_SHUT;
      default: st_d = K_SHUT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= K_SHUT;
    else        st_q <= st_d;
  end

  assign grant = (st_q == K_OPEN) && wr_en && is_prot;

  p_one_shot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> st_q == K_SHUT);
  p_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == K_HALF && wr_en && !(is_rld && wr_byte == KEY_B)) |=> st_q == K_SHUT);
  p_shut_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == K_SHUT && !(wr_en && is_rld && wr_byte == KEY_A)) |=> st_q == K_SHUT);
endmodule

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int SLOW_LOG2 = 15,
  parameter int FAST_LOG2 = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  output logic tick
);
  logic [SLOW_LOG2-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign tick = fast ? (&pre_q[FAST_LOG2-1:0]) : (&pre_q);

  p_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fast && FAST_LOG2 > 0) |=> !tick);
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int              CW      = 20,
  parameter logic [CW-1:0]   PRE_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          reload,
  input  logic [CW-1:0] pre1,
  input  logic [CW-1:0] pre2,
  output logic [CW-1:0] cnt,
  output logic          stage2,
  output logic          s1_exp,
  output logic          s2_exp
);
  logic step, at_zero;

  assign step    = en && tick && !reload;
  assign at_zero = (cnt == '0);
  assign s1_exp  = step && at_zero && !stage2;
  assign s2_exp  = step && at_zero && stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= PRE_RST;
      stage2 <= 1'b0;
    end else if (reload) begin
      cnt    <= pre1;
      stage2 <= 1'b0;
    end else if (s1_exp) begin
      cnt    <= pre2;
      stage2 <= 1'b1;
    end else if (s2_exp) begin
      cnt    <= pre1;
      stage2 <= 1'b0;
    end else if (step) begin
      cnt    <= cnt - 1'b1;
    end
  end

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt == $past(pre1)) && !stage2);
  p_stage_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s1_exp |=> stage2 && (cnt == $past(pre2)));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !reload) |=> $stable(cnt) && $stable(stage2));
  p_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_zero) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdog_pkg::*;
#(
  parameter int            CW        = 20,
  parameter int            SLOW_LOG2 = 15,
  parameter int            FAST_LOG2 = 5,
  parameter logic [CW-1:0] PRE_RST   = '1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq,
  output logic        rst_req
);
  logic [CW-1:0] pre1_q, pre2_q, cnt;
  logic [1:0]    irq_type_q;
  logic          fast_q, boot_q;
  logic          lock_q, en_q, timer_mode_q;
  logic          pend_q, flag_q, req_q;
  logic          is_rld, is_prot, grant, tick, reload, stage2, s1_exp, s2_exp;
  logic          wr_cfg, wr_lock, wr_stat, flag_clr;
  logic          unused_bits;

  assign unused_bits = ^wr_data;

  assign is_rld  = (wr_addr == A_RLD);
  assign is_prot = (wr_addr == A_PRE1) || (wr_addr == A_PRE2) || is_rld;
  assign wr_cfg  = wr_en && (wr_addr == A_CFG);
  assign wr_lock = wr_en && (wr_addr == A_LOCK);
  assign wr_stat = wr_en && (wr_addr == A_STAT);
  assign reload   = grant && is_rld && wr_data[RLD_GO_BIT];
  assign flag_clr = grant && is_rld && wr_data[RLD_FLAG_BIT];

  wdog_key u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .is_rld(is_rld),
    .is_prot(is_prot), .wr_byte(wr_data[7:0]), .grant(grant)
  );

  wdog_tick #(.SLOW_LOG2(SLOW_LOG2), .FAST_LOG2(FAST_LOG2)) u_tick (
    .clk(clk), .rst_n(rst_n), .fast(fast_q), .tick(tick)
  );

  wdog_count #(.CW(CW), .PRE_RST(PRE_RST)) u_count (
    .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick), .reload(reload),
    .pre1(pre1_q), .pre2(pre2_q), .cnt(cnt), .stage2(stage2),
    .s1_exp(s1_exp), .s2_exp(s2_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre1_q       <= PRE_RST;
      pre2_q       <= PRE_RST;
      irq_type_q   <= 2'b00;
      fast_q       <= 1'b0;
      boot_q       <= 1'b0;
      lock_q       <= 1'b0;
      en_q         <= 1'b0;
      timer_mode_q <= 1'b0;
      pend_q       <= 1'b0;
      req_q        <= 1'b0;
    end else begin
      if (grant && wr_addr == A_PRE1) pre1_q <= wr_data[CW-1:0];
      if (grant && wr_addr == A_PRE2) pre2_q <= wr_data[CW-1:0];
      if (wr_cfg) begin
        irq_type_q <= wr_data[1:0];
        fast_q     <= wr_data[CFG_FAST_BIT];
        boot_q     <= wr_data[CFG_BOOT_BIT];
      end
      if (wr_lock && !lock_q) begin
        lock_q       <= wr_data[0];
        en_q         <= wr_data[1];
        timer_mode_q <= wr_data[2];
      end
      if (s1_exp)                     pend_q <= 1'b1;
      else if (wr_stat && wr_data[0]) pend_q <= 1'b0;
      if (s2_exp && boot_q && !timer_mode_q) req_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                       flag_q <= 1'b0;
    else if (s2_exp && !timer_mode_q) flag_q <= 1'b1;
    else if (flag_clr)                flag_q <= 1'b0;
  end

  assign irq     = pend_q && en_q && (irq_type_q != 2'b11);
  assign rst_req = req_q;

  always_comb begin
    unique case (rd_addr)
      A_PRE1:  rd_data = 32'(pre1_q);
      A_PRE2:  rd_data = 32'(pre2_q);
      A_STAT:  rd_data = 32'(pend_q);
      A_RLD:   rd_data = 32'({flag_q, 9'b0});
      A_CFG:   rd_data = 32'({boot_q, 2'b00, fast_q, irq_type_q});
      A_LOCK:  rd_data = 32'({timer_mode_q, en_q, lock_q});
      A_CNT:   rd_data = 32'({stage2, cnt});
      default: rd_data = 32'd0;
    endcase
  end

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  p_lock_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q && $stable(en_q) && $stable(timer_mode_q));
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!por_n)
    (flag_q && !flag_clr) |=> flag_q);
  p_timer_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_mode_q && !rst_req) |=> !rst_req);
endmodule

// File: tb/test_keyed_wdog.sv
module test_keyed_wdog;
  localparam int NV = 33;
  localparam logic [2:0] PRE1 = 3'd0, PRE2 = 3'd1, STAT = 3'd2, RLD = 3'd3,
                         CFG = 3'd4, LCK = 3'd5, CNT = 3'd6;
  localparam logic [31:0] RST_V = 32'h000F_FFFF;

  // {requirement, read-check(1)/write(0), address, data}
  localparam logic [39:0] VEC [NV] = '{
    {4'd3, 1'b0, PRE1, 32'h10},   // R3 locked write
    {4'd3, 1'b1, PRE1, RST_V},
    {4'd3, 1'b0, RLD,  32'h100},  // R3 locked reload
    {4'd3, 1'b1, CNT,  RST_V},
    {4'd1, 1'b0, RLD,  32'h80},   // R1 key
    {4'd1, 1'b0, RLD,  32'h86},
    {4'd1, 1'b0, PRE1, 32'h10},
    {4'd1, 1'b1, PRE1, 32'h10},
    {4'd1, 1'b0, PRE1, 32'h20},   // R1 second write refused
    {4'd1, 1'b1, PRE1, 32'h10},
    {4'd2, 1'b0, RLD,  32'h80},   // R2 other address between
    {4'd2, 1'b0, PRE2, 32'h5},
    {4'd2, 1'b0, PRE2, 32'h6},
    {4'd2, 1'b1, PRE2, RST_V},
    {4'd2, 1'b0, RLD,  32'h80},   // R2 wrong second byte
    {4'd2, 1'b0, RLD,  32'h85},
    {4'd2, 1'b0, RLD,  32'h86},
    {4'd2, 1'b0, PRE2, 32'h7},
    {4'd2, 1'b1, PRE2, RST_V},
    {4'd2, 1'b0, RLD,  32'h80},   // R2 config write between
    {4'd2, 1'b0, CFG,  32'h3},
    {4'd2, 1'b0, RLD,  32'h86},
    {4'd2, 1'b0, PRE2, 32'h7},
    {4'd2, 1'b1, PRE2, RST_V},
    {4'd2, 1'b1, CFG,  32'h3},
    {4'd1, 1'b0, RLD,  32'h80},
    {4'd1, 1'b0, RLD,  32'h86},
    {4'd1, 1'b0, PRE2, 32'h7},
    {4'd1, 1'b1, PRE2, 32'h7},
    {4'd4, 1'b0, RLD,  32'h80},   // R4 reload, R11 readback
    {4'd4, 1'b0, RLD,  32'h86},
    {4'd4, 1'b0, RLD,  32'h100},
    {4'd4, 1'b1, CNT,  32'h10}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq, rst_req;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  keyed_wdog #(.SLOW_LOG2(6), .FAST_LOG2(2)) i_keyed_wdog (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .rst_req(rst_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic unlock();
    wr(RLD, 32'h80);
    wr(RLD, 32'h86);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual running expected done");
    finish_run();
  end

  initial begin
    logic [31:0] v, c0;
    int g;
    repeat (4) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    rd(CNT, v);  check("R13 count", v, RST_V);
    rd(PRE1, v); check("R13 pre1", v, RST_V);
    rd(CFG, v);  check("R13 cfg", v, 0);
    rd(LCK, v);  check("R13 lock", v, 0);
    rd(STAT, v); check("R13 stat", v, 0);
    rd(RLD, v);  check("R10 flag after por", v, 0);
    check("R13 irq/rst_req", {30'd0, irq, rst_req}, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][35]) begin
        rd(VEC[i][34:32], v);
        checks++;
        if (v !== VEC[i][31:0]) begin
          errors++;
          $display("FAIL R%0d vector %0d: actual %h expected %h",
                   VEC[i][39:36], i, v, VEC[i][31:0]);
        end
      end else begin
        wr(VEC[i][34:32], VEC[i][31:0]);
      end
    end

    // R9 slow rate: 128 clocks -> 2 ticks
    wr(CFG, 32'h20);
    wr(LCK, 32'h2);
    rd(CNT, c0);
    repeat (128) @(negedge clk);
    rd(CNT, v); check("R9 slow rate", v, c0 - 2);
    // R9 fast rate: 16 clocks -> 4 ticks
    wr(CFG, 32'h24);
    rd(CNT, c0);
    repeat (16) @(negedge clk);
    rd(CNT, v); check("R9 fast rate", v, c0 - 4);

    // R5 stage-1 expiry
    g = 0;
    while (!irq && g < 2000) begin @(negedge clk); g++; end
    check("R5 irq raised", {31'd0, irq}, 1);
    rd(CNT, v);  check("R5 stage2 loaded", v, 32'h0010_0007);
    rd(STAT, v); check("R5 status set", v, 1);
    // R6 stage-2 expiry after exactly 4*(7+1) clocks
    g = 0;
    while (!rst_req && g < 1000) begin @(negedge clk); g++; end
    check("R6 stage2 length", g, 32);
    rd(CNT, v); check("R6 restart stage1", v, 32'h10);
    rd(RLD, v); check("R10 flag set", v, 32'h200);

    // R8 disable holds count and masks irq
    wr(LCK, 32'h0);
    check("R8 irq masked", {31'd0, irq}, 0);
    rd(CNT, c0);
    repeat (20) @(negedge clk);
    rd(CNT, v); check("R8 count held", v, c0);
    wr(LCK, 32'h2);
    check("R5 irq back", {31'd0, irq}, 1);
    wr(STAT, 32'h1);
    check("R5 irq cleared", {31'd0, irq}, 0);
    check("R6 rst_req held", {31'd0, rst_req}, 1);

    // R10 flag survives block reset
    rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    check("R6 rst_req cleared by rst_n", {31'd0, rst_req}, 0);
    rd(RLD, v); check("R10 flag survives rst_n", v, 32'h200);
    unlock(); wr(RLD, 32'h200);
    rd(RLD, v); check("R10 flag cleared", v, 0);

    // R12 free-timer mode
    unlock(); wr(PRE1, 32'h8);
    unlock(); wr(PRE2, 32'h3);
    unlock(); wr(RLD, 32'h100);
    wr(CFG, 32'h24);
    wr(LCK, 32'h6);
    repeat (200) @(negedge clk);
    check("R12 no reset request", {31'd0, rst_req}, 0);
    rd(RLD, v); check("R12 no flag", v, 0);
    check("R12 stage1 still interrupts", {31'd0, irq}, 1);

    // R7 lock
    wr(LCK, 32'h7);
    wr(LCK, 32'h0);
    rd(LCK, v); check("R7 locked", v, 32'h7);
    rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    rd(LCK, v); check("R7 released by rst_n", v, 0);

    finish_run();
  end
endmodule